// File: doc/BRIEF.md
# I2C Bus Recovery and Chain Probe Sequencer

This block is the single bus master on a private two-wire serial chain. When software or boot logic pulses a request, it first frees the bus from any half-finished transfer. To do this it holds the clock low, releases the data line, and then clocks up to nine pulses until it sees data released. It then marks the bus idle with a START followed by a STOP. After that it tries, one at a time, a fixed set of device addresses to learn which board arrangement is fitted. Both wires are driven only as open-drain pull-down enables: a 1 on an enable pulls the wire low and a 0 releases it. The block never drives a wire high.

A probe is a recovery, a START, the address byte with the read bit set, and an acknowledge slot. When a device answers, the block clocks in one full data byte and only then sends a STOP, because some parts cannot take a STOP directly after acknowledging. The first address that answers sets the chain type, which is kept until reset. Later requests return at once without touching the bus. The type also selects the memory and sensor addresses that the rest of the chip uses. When nothing answers, the type stays unknown and the next request probes again. A bus that cannot be freed is reported as stuck.

Top module: `i2c_chain_probe`

## Requirements
- R1: The outputs scl_oe_o and sda_oe_o are pull-down enables (1 = drive low, 0 = release). After reset both are 0, done_o is 0, res_o is 0 (no result), chain_o is 0, and eep_addr_o and sens_addr_o are 0xFF.
- R2: Recovery drives SCL low with SDA released. It then releases SCL and samples SDA, and repeats this for at most 9 clock pulses. The first released SDA is followed by START, SCL low, SCL release, SDA release (STOP), and the sequence goes on. An SDA that is held low for 8 high phases and released on the 9th still gives success.
- R3: If SDA stays low through all 9 recovery high phases, the request ends with res_o = 3 (bus stuck) and chain_o = 0. No address byte is sent, and exactly 9 SCL rising edges occur.
- R4: Probes use the byte address|1 (bit 0 = read), sent MSB first, in the fixed order 0xA4, 0xA0, 0xA2, so the bus carries 0xA5, 0xA1, 0xA3. Each probe is preceded by its own recovery.
- R5: When a device pulls SDA low in the acknowledge slot, the block gives exactly 8 further SCL clocks to read one byte, sends no acknowledge, and then generates STOP.
- R6: A successful probe sets chain_o to the table position plus one: 1 for 0xA4, 2 for 0xA0, 3 for 0xA2. A nonzero chain_o holds its value until reset.
- R7: A request made while chain_o is nonzero raises done_o on the next clock with res_o = 1 and makes no SCL edge.
- R8: When the 0xA4 (legacy) entry answers, one more full bus recovery (with its own START) runs after the probe's STOP, before done_o.
- R9: eep_addr_o/sens_addr_o are 0xA0/0x98 for chain 2, 0xA2/0x98 for chain 3, and 0xFF/0xFF for chain 1 and chain 0.
- R10: If no table entry acknowledges, res_o = 2 (no device) and chain_o stays 0. The next request probes the whole table again.
- R11: done_o is a one-cycle pulse at the end of each request. res_o keeps its value after the pulse until the next request, and res_o = 1 means success.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request pulse, taken when idle |
| sda_i | input | 1 | Sampled level of the SDA wire |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | One-cycle end-of-request pulse |
| res_o | output | 2 | 0 none, 1 ok, 2 no device, 3 bus stuck |
| chain_o | output | 2 | Stored chain type, 0 = unknown |
| eep_addr_o | output | 8 | Memory device address for the chain, 0xFF if none |
| sens_addr_o | output | 8 | Sensor device address for the chain, 0xFF if none |

## Verification
The assertions watch, on every cycle, the rules that link the result outputs over time. These are that done lasts one cycle, that a stored chain type never changes, that a request with a known type completes on the next clock with success, that failures leave the type at zero, and that the bus is released whenever a type is known. Only the bench scenarios can show what happens on the wire. Its bus device model watches the wire to check the order of the probed address bytes, the count of recovery pulses against a data line held low for a set number of clocks, the eight read clocks after an acknowledge, and the extra recovery that follows a legacy match.

// File: rtl/i2c_probe_pkg.sv
`timescale 1ns/1ps
package i2c_probe_pkg;

  localparam int          NUM_CHAINS = 3;
  localparam logic [7:0]  ADDR_NONE  = 8'hFF;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_OK    = 2'd1,
    RES_NODEV = 2'd2,
    RES_STUCK = 2'd3
  } probe_res_e;

  // Each state is one bus phase; the comment gives SCL/SDA enable.
  typedef enum logic [4:0] {
    SQ_IDLE,   // rel / rel
    SQ_RC_LO,  // low / rel   recovery clock low
    SQ_RC_HI,  // rel / rel   recovery clock high, sample SDA
    SQ_RC_S1,  // rel / low   START
    SQ_RC_S2,  // low / low
    SQ_RC_S3,  // rel / low
    SQ_RC_S4,  // rel / rel   STOP
    SQ_ST,     // rel / low   probe START
    SQ_WA,     // low / bit
    SQ_WB,     // rel / bit
    SQ_AA,     // low / rel
    SQ_AB,     // rel / rel   sample acknowledge
    SQ_RA,     // low / rel
    SQ_RB,     // rel / rel   read clock
    SQ_SP1,    // low / low
    SQ_SP2,    // rel / low
    SQ_SP3     // rel / rel   STOP
  } seq_state_e;

endpackage

// File: rtl/i2c_phase_timer.sv
`timescale 1ns/1ps
module i2c_phase_timer #(
  parameter int PHASE_CYCLES = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(PHASE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/i2c_chain_table.sv
`timescale 1ns/1ps
module i2c_chain_table
  import i2c_probe_pkg::*;
(
  input  logic [1:0] probe_idx_i,
  input  logic [1:0] chain_i,
  output logic [7:0] probe_addr_o,
  output logic [7:0] eep_addr_o,
  output logic [7:0] sens_addr_o
);
  always_comb begin
    case (probe_idx_i)
      2'd0:    probe_addr_o = 8'hA4;
      2'd1:    probe_addr_o = 8'hA0;
      2'd2:    probe_addr_o = 8'hA2;
      default: probe_addr_o = ADDR_NONE;
    endcase
  end

  always_comb begin
    case (chain_i)
      2'd2:    begin eep_addr_o = 8'hA0;     sens_addr_o = 8'h98;     end
      2'd3:    begin eep_addr_o = 8'hA2;     sens_addr_o = 8'h98;     end
      default: begin eep_addr_o = ADDR_NONE; sens_addr_o = ADDR_NONE; end
    endcase
  end
endmodule

// File: rtl/i2c_chain_probe.sv
`timescale 1ns/1ps
module i2c_chain_probe
  import i2c_probe_pkg::*;
#(
  parameter int PHASE_CYCLES    = 125,
  parameter int RECOVERY_CLOCKS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       done_o,
  output logic [1:0] res_o,
  output logic [1:0] chain_o,
  output logic [7:0] eep_addr_o,
  output logic [7:0] sens_addr_o
);
  localparam int CNT_W = $clog2((RECOVERY_CLOCKS > 8) ? RECOVERY_CLOCKS : 8);
  localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(RECOVERY_CLOCKS - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(7);
  localparam logic [1:0]       IDX_LAST  = 2'(NUM_CHAINS - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_in_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       idx_q, idx_d, chain_q, chain_d;
  logic             post_q, post_d, done_q, done_d;
  probe_res_e       res_q, res_d;
  logic             tick, sda_s1_q, sda_s2_q;
  logic             scl_want, sda_want, scl_q, sda_p_q, sda_q;
  logic [7:0]       probe_addr, tx_sh;

  i2c_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_in_n), .run_i(state_q != SQ_IDLE), .tick_o(tick)
  );

  i2c_chain_table u_table (
    .probe_idx_i(idx_q), .chain_i(chain_q), .probe_addr_o(probe_addr),
    .eep_addr_o(eep_addr_o), .sens_addr_o(sens_addr_o)
  );

  assign tx_sh = (probe_addr | 8'h01) << cnt_q[2:0];

  // line enables for the current phase
  always_comb begin
    scl_want = 1'b0;
    sda_want = 1'b0;
    case (state_q)
      SQ_RC_LO, SQ_AA, SQ_RA:  scl_want = 1'b1;
      SQ_RC_S1, SQ_RC_S3,
      SQ_ST, SQ_SP2:           sda_want = 1'b1;
      SQ_RC_S2, SQ_SP1:        begin scl_want = 1'b1; sda_want = 1'b1; end
      SQ_WA:                   begin scl_want = 1'b1; sda_want = ~tx_sh[7]; end
      SQ_WB:                   sda_want = ~tx_sh[7];
      default:                 ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    post_d  = post_q;
    chain_d = chain_q;
    res_d   = res_q;
    done_d  = 1'b0;
    if (state_q == SQ_IDLE) begin
      if (start_i) begin
        if (chain_q != 2'd0) begin
          done_d = 1'b1;
          res_d  = RES_OK;
        end else begin
          res_d   = RES_NONE;
          idx_d   = 2'd0;
          post_d  = 1'b0;
          cnt_d   = '0;
          state_d = SQ_RC_LO;
        end
      end
    end else if (tick) begin
      case (state_q)
        SQ_RC_LO: state_d = SQ_RC_HI;
        SQ_RC_HI: begin
          if (sda_s2_q) state_d = SQ_RC_S1;
          else if (cnt_q == REC_LAST) begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
            res_d   = post_q ? RES_OK : RES_STUCK;
            chain_d = post_q ? idx_q + 2'd1 : 2'd0;
          end else begin
            cnt_d   = cnt_q + 1'b1;
            state_d = SQ_RC_LO;
          end
        end
        SQ_RC_S1: state_d = SQ_RC_S2;
        SQ_RC_S2: state_d = SQ_RC_S3;
        SQ_RC_S3: state_d = SQ_RC_S4;
        SQ_RC_S4: begin
          if (post_q) begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
            res_d   = RES_OK;
            chain_d = idx_q + 2'd1;
          end else state_d = SQ_ST;
        end
        SQ_ST: begin cnt_d = '0; state_d = SQ_WA; end
        SQ_WA: state_d = SQ_WB;
        SQ_WB: begin
          if (cnt_q == BYTE_LAST) state_d = SQ_AA;
          else begin cnt_d = cnt_q + 1'b1; state_d = SQ_WA; end
        end
        SQ_AA: state_d = SQ_AB;
        SQ_AB: begin
          cnt_d = '0;
          if (!sda_s2_q) state_d = SQ_RA;
          else if (idx_q == IDX_LAST) begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
            res_d   = RES_NODEV;
          end else begin
            idx_d   = idx_q + 2'd1;
            state_d = SQ_RC_LO;
          end
        end
        SQ_RA: state_d = SQ_RB;
        SQ_RB: begin
          if (cnt_q == BYTE_LAST) state_d = SQ_SP1;
          else begin cnt_d = cnt_q + 1'b1; state_d = SQ_RA; end
        end
        SQ_SP1: state_d = SQ_SP2;
        SQ_SP2: state_d = SQ_SP3;
        SQ_SP3: begin
          cnt_d = '0;
          if (idx_q == 2'd0) begin
            post_d  = 1'b1;
            state_d = SQ_RC_LO;
          end else begin
            state_d = SQ_IDLE;
            done_d  = 1'b1;
            res_d   = RES_OK;
            chain_d = idx_q + 2'd1;
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      idx_q    <= 2'd0;
      post_q   <= 1'b0;
      chain_q  <= 2'd0;
      res_q    <= RES_NONE;
      done_q   <= 1'b0;
      sda_s1_q <= 1'b1;
      sda_s2_q <= 1'b1;
      scl_q    <= 1'b0;
      sda_p_q  <= 1'b0;
      sda_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      post_q   <= post_d;
      chain_q  <= chain_d;
      res_q    <= res_d;
      done_q   <= done_d;
      sda_s1_q <= sda_i;
      sda_s2_q <= sda_s1_q;
      scl_q    <= scl_want;
      sda_p_q  <= sda_want;
      sda_q    <= sda_p_q;   // SDA moves one clock after SCL
    end
  end

  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;
  assign done_o   = done_q;
  assign res_o    = res_q;
  assign chain_o  = chain_q;
endmodule

// File: rtl/i2c_probe_chk.sv
`timescale 1ns/1ps
module i2c_probe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       done_o,
  input logic [1:0] res_o,
  input logic [1:0] chain_o
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_o != 2'd0) |=> $stable(chain_o));

  a_r7_known_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && chain_o != 2'd0) |=> (done_o && res_o == 2'd1));

  a_r10_fail_no_type: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && res_o != 2'd1) |-> (chain_o == 2'd0));

  a_r11_ok_has_type: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && res_o == 2'd1) |-> (chain_o != 2'd0));

  a_r1_bus_free_when_known: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_o != 2'd0) |-> (!scl_oe_o && !sda_oe_o));
endmodule

bind i2c_chain_probe i2c_probe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o), .done_o(done_o), .res_o(res_o), .chain_o(chain_o)
);

// File: tb/sim_i2c_chain_probe.sv
`timescale 1ns/1ps
module sim_i2c_chain_probe;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic scl_oe, sda_oe, done_o;
  logic [1:0] res_o, chain_o;
  logic [7:0] eep_o, sens_o;
  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  // bus device model
  logic [7:0] tgt = 8'h00;
  int stuck_n = 0;
  int fall_base = 0;
  localparam logic [7:0] RD_BYTE = 8'h5A;
  logic scl_w, sda_w, stuck_low, p_scl, p_sda, s_drv;
  int s_state, s_bits, dc, fall_cnt, rise_cnt, n_start, n_addr, d_clks;
  logic [7:0] s_sh;
  logic [7:0] addr_log [0:63];

  assign stuck_low = (stuck_n != 0) && ((fall_cnt - fall_base) <= stuck_n);
  assign scl_w = ~scl_oe;
  assign sda_w = ~sda_oe & ~s_drv & ~stuck_low;

  initial begin
    p_scl = 1'b1; p_sda = 1'b1; s_drv = 1'b0; s_state = 0; s_bits = 0; dc = 0;
    fall_cnt = 0; rise_cnt = 0; n_start = 0; n_addr = 0; d_clks = 0; s_sh = 8'h00;
  end

  always @(posedge clk) begin
    p_scl <= scl_w;
    p_sda <= sda_w;
    if (scl_w && p_scl && p_sda && !sda_w && !stuck_low) begin
      n_start <= n_start + 1; s_state <= 1; s_bits <= 0;
    end else if (scl_w && p_scl && !p_sda && sda_w) begin
      s_state <= 0; s_drv <= 1'b0;
    end else if (scl_w && !p_scl) begin
      rise_cnt <= rise_cnt + 1;
      if (s_state == 1) begin s_sh <= {s_sh[6:0], sda_w}; s_bits <= s_bits + 1; end
      if (s_state == 3) begin d_clks <= d_clks + 1; dc <= dc + 1; end
    end else if (!scl_w && p_scl) begin
      fall_cnt <= fall_cnt + 1;
      if (s_state == 1 && s_bits == 8) begin
        addr_log[n_addr[5:0]] <= s_sh;
        n_addr <= n_addr + 1;
        if (s_sh == tgt) begin s_drv <= 1'b1; s_state <= 2; end
        else s_state <= 0;
      end else if (s_state == 2) begin
        s_drv <= ~RD_BYTE[7]; s_state <= 3; dc <= 0;
      end else if (s_state == 3) begin
        if (dc == 8) begin s_drv <= 1'b0; s_state <= 0; end
        else s_drv <= ~RD_BYTE[3'(7 - dc)];
      end
    end
  end

  i2c_chain_probe #(.PHASE_CYCLES(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .done_o(done_o), .res_o(res_o),
    .chain_o(chain_o), .eep_addr_o(eep_o), .sens_addr_o(sens_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  int b_addr, b_start, b_rise, b_dclk, wait_cyc;

  task automatic request();
    b_addr = n_addr; b_start = n_start; b_rise = rise_cnt; b_dclk = d_clks;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    wait_cyc = 1;
    while (!done_o && wait_cyc < 20000) begin
      @(negedge clk);
      wait_cyc++;
    end
    chk("R11 done seen", int'(done_o), 1);
    @(negedge clk);
    chk("R11 done one cycle", int'(done_o), 0);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R1 scl released", int'(scl_oe), 0);
    chk("R1 sda released", int'(sda_oe), 0);
    chk("R1 done low", int'(done_o), 0);
    chk("R1 res none", int'(res_o), 0);
    chk("R1 chain unknown", int'(chain_o), 0);
    chk("R9 eep none", int'(eep_o), 8'hFF);
  endtask

  task automatic t_no_device();
    tgt = 8'h00; stuck_n = 0;
    request();
    chk("R10 res no device", int'(res_o), 2);
    chk("R10 chain zero", int'(chain_o), 0);
    chk("R4 three probes", n_addr - b_addr, 3);
    chk("R4 first A5", int'(addr_log[b_addr]), 8'hA5);
    chk("R4 second A1", int'(addr_log[b_addr+1]), 8'hA1);
    chk("R4 third A3", int'(addr_log[b_addr+2]), 8'hA3);
    chk("R4 start per probe", n_start - b_start, 6);
    chk("R9 sens none", int'(sens_o), 8'hFF);
  endtask

  task automatic t_retry_a2();
    tgt = 8'hA3;
    request();
    chk("R10 retry ok", int'(res_o), 1);
    chk("R6 chain 3", int'(chain_o), 3);
    chk("R10 retry reprobes", n_addr - b_addr, 3);
    chk("R5 eight read clocks", d_clks - b_dclk, 8);
    chk("R5 bus idle after stop", int'(scl_w & sda_w), 1);
    chk("R9 eep A2", int'(eep_o), 8'hA2);
    chk("R9 sens 98", int'(sens_o), 8'h98);
  endtask

  task automatic t_known_skip();
    request();
    chk("R7 done next cycle", wait_cyc, 1);
    chk("R7 no bus clock", rise_cnt - b_rise, 0);
    chk("R7 res ok", int'(res_o), 1);
    repeat (50) @(negedge clk);
    chk("R6 chain held", int'(chain_o), 3);
    chk("R11 res held", int'(res_o), 1);
  endtask

  task automatic t_legacy();
    tgt = 8'hA5;
    request();
    chk("R6 chain 1", int'(chain_o), 1);
    chk("R8 res ok", int'(res_o), 1);
    chk("R8 extra recovery start", n_start - b_start, 3);
    chk("R8 one address", n_addr - b_addr, 1);
    chk("R9 legacy eep none", int'(eep_o), 8'hFF);
    chk("R9 legacy sens none", int'(sens_o), 8'hFF);
  endtask

  task automatic t_chain_a0();
    tgt = 8'hA1;
    request();
    chk("R6 chain 2", int'(chain_o), 2);
    chk("R4 order A5 then A1", int'(addr_log[b_addr+1]), 8'hA1);
    chk("R4 two recoveries two probes", n_start - b_start, 4);
    chk("R9 eep A0", int'(eep_o), 8'hA0);
    chk("R9 sens 98 chain2", int'(sens_o), 8'h98);
  endtask

  task automatic t_stuck(input int k);
    tgt = 8'hA1;
    fall_base = fall_cnt; stuck_n = k;
    request();
    if (k < 9) begin
      chk("R2 recovered on last clock", int'(res_o), 1);
      chk("R2 chain found", int'(chain_o), 2);
    end else begin
      chk("R3 res stuck", int'(res_o), 3);
      chk("R3 chain zero", int'(chain_o), 0);
      chk("R3 no address sent", n_addr - b_addr, 0);
      chk("R3 nine clocks", rise_cnt - b_rise, 9);
    end
    stuck_n = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_state();
    t_no_device();
    t_retry_a2();
    t_known_skip();
    do_reset();
    t_reset_state();
    t_legacy();
    do_reset();
    t_chain_a0();
    do_reset();
    t_stuck(8);
    do_reset();
    t_stuck(9);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule